// File: doc/BRIEF.md
# Multiple-Register Block Transfer Sequencer

This block executes one block data transfer of a 32-bit load/store processor: it copies a chosen set of general registers to consecutive memory words, or fills them from consecutive memory words. A command gives a 16-bit selection mask (bit i selects register i), the index of the base register, the direction, the stepping direction, whether the step comes before or after each access, whether the final address is written back into the base, and whether a load of the program counter also refreshes the status word.

The sequencer reads register values through a combinational read port into the register file. It issues one word access per selected register over a request/acknowledge memory port, with at most one access in flight. Loaded words come back on a register-file write port. A loaded program counter goes to a dedicated program counter write port, together with the merged status word when requested. Register 15 is the program counter. Used as a base it supplies the program counter plus 8. It is always moved after every other selected register, and it is never the target of a base write-back.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, and whenever no command is running, `busy`, `mem_req` and `done` are 0.
- R2: The starting address is the base register's value, or `pc_in` + 8 when `cmd_base` is 15; `pc_in` is sampled when the command is accepted.
- R3: Each access moves the address by +4 when `cmd_up`=1 and by -4 when `cmd_up`=0; with `cmd_pre`=1 the step is applied before each access, with `cmd_pre`=0 after it.
- R4: Registers 0 to 14 whose mask bit is 1 are accessed in ascending index order, one access each, and unselected registers are never accessed.
- R5: A selected register 15 is accessed after all others; a store (`cmd_load`=0) of register 15 writes the sampled `pc_in` + 12.
- R6: On a load (`cmd_load`=1), the acknowledged word is written to the register file in the acknowledge cycle for registers 0 to 14, and to `pc_wdata` with `pc_we` for register 15.
- R7: With `cmd_wb`=1 and a base other than 15, the address after the last step is written into the base register in the `done` cycle; with `cmd_wb`=0 or base 15, no base write happens.
- R8: A load of register 15 with `cmd_psr`=1 sets `psr_we`. If `mode_user` was 1 when the command was accepted, the bits of mask 0x0C000003 keep their `psr_in` value and the others take the loaded word; otherwise the whole loaded word is taken. With `cmd_psr`=0, `psr_we` stays 0.
- R9: An all-zero mask makes no memory access and raises `done` in the cycle after the command is accepted.
- R10: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`; `done` is a one-cycle pulse in the cycle after the last acknowledge.
- R11: `mem_addr` always has its two low bits at 0, even for an unaligned base value.
- R12: `start` is ignored while a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a command when idle |
| cmd_mask | input | 16 | Register selection, bit i = register i |
| cmd_base | input | 4 | Base register index |
| cmd_load | input | 1 | 1 = load from memory, 0 = store |
| cmd_up | input | 1 | 1 = step +4, 0 = step -4 |
| cmd_pre | input | 1 | 1 = step before each access |
| cmd_wb | input | 1 | Write final address into base |
| cmd_psr | input | 1 | Loading r15 also updates the status word |
| mode_user | input | 1 | Current mode is unprivileged |
| pc_in | input | 32 | Current program counter |
| psr_in | input | 32 | Current status word |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | 32 | New program counter |
| psr_we | output | 1 | Status word write enable |
| psr_wdata | output | 32 | New status word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions share a cycle. The last load's register write lands in the acknowledge cycle, and the base write-back lands in the following `done` cycle; a load with write-back and a base outside the list provokes that pair, judged by the final register contents and by the cycle of `done` against the recorded last acknowledge. A program-counter load with the status flag set writes the program counter and the status word in the same acknowledge cycle; it is run once in unprivileged mode, with `mode_user` dropped right after acceptance, and once privileged, and both written values are compared against hand-computed merges.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_st_t;

endpackage

// File: rtl/blkxfer_pick.sv
// Lowest-set-bit picker over the pending register mask.
module blkxfer_pick #(
   parameter int REGS = 16,
   parameter int IDXW = 4
) (
   input  logic [REGS-1:0] pend,
   output logic [IDXW-1:0] idx,
   output logic [REGS-1:0] sel,
   output logic            last
);

   genvar g;
   generate
      for (g = 0; g < REGS; g++) begin : g_slot
         if (g == 0) begin : g_first
            assign sel[g] = pend[g];
         end else begin : g_rest
            assign sel[g] = pend[g] & ~(|pend[g-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < REGS; i++) begin
         if (sel[i]) idx = idx | IDXW'(i);
      end
   end

   assign last = ((pend & ~sel) == '0);

endmodule

// File: rtl/blkxfer_addr.sv
// Running address register with pre/post stepping and word alignment.
module blkxfer_addr #(
   parameter int DW    = 32,
   parameter int BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [DW-1:0] load_val,
   input  logic          adv,
   input  logic          up,
   input  logic          pre,
   output logic [DW-1:0] cur,
   output logic [DW-1:0] bus_addr
);

   localparam int ALB = $clog2(BYTES);

   logic [DW-1:0] cur_q;
   logic [DW-1:0] nxt;
   logic [DW-1:0] chosen;

   assign nxt    = up ? cur_q + DW'(BYTES) : cur_q - DW'(BYTES);
   assign chosen = pre ? nxt : cur_q;
   assign cur    = cur_q;

   generate
      if (ALB > 0) begin : g_align
         assign bus_addr = {chosen[DW-1:ALB], {ALB{1'b0}}};
      end else begin : g_noalign
         assign bus_addr = chosen;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur_q <= '0;
      else if (load_en) cur_q <= load_val;
      else if (adv)     cur_q <= nxt;
   end

endmodule

// File: rtl/blkxfer_psr.sv
// Status word merge for a program counter load with status update.
module blkxfer_psr #(
   parameter int          DW        = 32,
   parameter logic [31:0] PROT_MASK = 32'h0C00_0003
) (
   input  logic [DW-1:0] old_psr,
   input  logic [DW-1:0] loaded,
   input  logic          protect,
   output logic [DW-1:0] merged
);

   localparam logic [DW-1:0] KEEP = DW'(PROT_MASK);

   assign merged = protect ? ((old_psr & KEEP) | (loaded & ~KEEP)) : loaded;

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int          DW           = 32,
   parameter int          REGS         = 16,
   parameter int          PC_BASE_OFS  = 8,
   parameter int          PC_STORE_OFS = 12,
   parameter logic [31:0] PROT_MASK    = 32'h0C00_0003,
   localparam int         IDXW         = $clog2(REGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [REGS-1:0] cmd_mask,
   input  logic [IDXW-1:0] cmd_base,
   input  logic            cmd_load,
   input  logic            cmd_up,
   input  logic            cmd_pre,
   input  logic            cmd_wb,
   input  logic            cmd_psr,
   input  logic            mode_user,
   input  logic [DW-1:0]   pc_in,
   input  logic [DW-1:0]   psr_in,
   output logic [IDXW-1:0] rf_rd_idx,
   input  logic [DW-1:0]   rf_rd_data,
   output logic            rf_we,
   output logic [IDXW-1:0] rf_wr_idx,
   output logic [DW-1:0]   rf_wdata,
   output logic            pc_we,
   output logic [DW-1:0]   pc_wdata,
   output logic            psr_we,
   output logic [DW-1:0]   psr_wdata,
   output logic            mem_req,
   output logic            mem_we,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ack,
   input  logic [DW-1:0]   mem_rdata,
   output logic            busy,
   output logic            done
);

   localparam int              BYTES  = DW / 8;
   localparam logic [IDXW-1:0] PC_IDX = IDXW'(REGS - 1);

   generate
      if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
         $error("blkxfer_seq: DW must be a multiple of 8 and at least 16");
      end
      if ((1 << IDXW) != REGS || REGS < 2) begin : g_bad_regs
         $error("blkxfer_seq: REGS must be a power of two, at least 2");
      end
      if ((PC_BASE_OFS % BYTES) != 0 || (PC_STORE_OFS % BYTES) != 0) begin : g_bad_ofs
         $error("blkxfer_seq: program counter offsets must be word multiples");
      end
   endgenerate

   seq_st_t         st;
   logic [REGS-1:0] mask_q;
   logic [IDXW-1:0] base_q;
   logic            load_q, up_q, pre_q, wb_q, psr_q, user_q;
   logic [DW-1:0]   pc_q;

   logic            start_ok, beat, last, wb_fire, ld_fire;
   logic [IDXW-1:0] cur_idx;
   logic [REGS-1:0] cur_sel;
   logic [DW-1:0]   base_val, addr_cur, merged_psr;

   assign start_ok = (st == ST_IDLE) && start;
   assign beat     = mem_req && mem_ack;
   assign base_val = (cmd_base == PC_IDX) ? pc_in + DW'(PC_BASE_OFS) : rf_rd_data;

   blkxfer_pick #(.REGS(REGS), .IDXW(IDXW)) u_pick (
      .pend (mask_q),
      .idx  (cur_idx),
      .sel  (cur_sel),
      .last (last)
   );

   blkxfer_addr #(.DW(DW), .BYTES(BYTES)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (start_ok),
      .load_val (base_val),
      .adv      (beat),
      .up       (up_q),
      .pre      (pre_q),
      .cur      (addr_cur),
      .bus_addr (mem_addr)
   );

   blkxfer_psr #(.DW(DW), .PROT_MASK(PROT_MASK)) u_psr (
      .old_psr (psr_in),
      .loaded  (mem_rdata),
      .protect (user_q),
      .merged  (merged_psr)
   );

   // Sequencer state and command capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mask_q <= '0;
         base_q <= '0;
         load_q <= 1'b0;
         up_q   <= 1'b0;
         pre_q  <= 1'b0;
         wb_q   <= 1'b0;
         psr_q  <= 1'b0;
         user_q <= 1'b0;
         pc_q   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  mask_q <= cmd_mask;
                  base_q <= cmd_base;
                  load_q <= cmd_load;
                  up_q   <= cmd_up;
                  pre_q  <= cmd_pre;
                  wb_q   <= cmd_wb;
                  psr_q  <= cmd_psr;
                  user_q <= mode_user;
                  pc_q   <= pc_in;
                  st     <= (cmd_mask == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (beat) begin
                  mask_q <= mask_q & ~cur_sel;
                  if (last) st <= ST_FIN;
               end
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Register file read port: base during idle, current register while running
   assign rf_rd_idx = (st == ST_IDLE) ? cmd_base : cur_idx;

   // Memory port
   assign mem_req   = (st == ST_RUN);
   assign mem_we    = mem_req && !load_q;
   assign mem_wdata = (cur_idx == PC_IDX) ? pc_q + DW'(PC_STORE_OFS) : rf_rd_data;

   // Register file write port: loaded word or base write-back
   assign ld_fire   = beat && load_q && (cur_idx != PC_IDX);
   assign wb_fire   = (st == ST_FIN) && wb_q && (base_q != PC_IDX);
   assign rf_we     = ld_fire || wb_fire;
   assign rf_wr_idx = wb_fire ? base_q : cur_idx;
   assign rf_wdata  = wb_fire ? addr_cur : mem_rdata;

   // Program counter and status word
   assign pc_we     = beat && load_q && (cur_idx == PC_IDX);
   assign pc_wdata  = mem_rdata;
   assign psr_we    = pc_we && psr_q;
   assign psr_wdata = merged_psr;

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_FIN);

   // ---------------- assertions ----------------
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !last) |=> (mem_req &&
         mem_addr == ($past(mem_addr) + ($past(up_q) ? DW'(BYTES) : -DW'(BYTES)))));

   p_pc_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && rf_rd_idx == PC_IDX) |-> last);

   p_pc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> (mem_ack && !mem_we));

   p_rf_no_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_wr_idx != PC_IDX));

   p_psr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (psr_we && user_q) |-> (((psr_wdata ^ psr_in) & DW'(PROT_MASK)) == '0));

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(beat) || $past(start_ok)));

   p_ignore_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(base_q) && $stable(load_q) && $stable(up_q)));

endmodule

// File: tb/blkxfer_seq_bench.sv
`timescale 1ns/1ps
module blkxfer_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cmd_mask = '0;
   logic [3:0]  cmd_base = '0;
   logic        cmd_load = 1'b0, cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wb = 1'b0, cmd_psr = 1'b0;
   logic        mode_user = 1'b0;
   logic [31:0] pc_in = '0, psr_in = '0;
   logic [3:0]  rf_rd_idx, rf_wr_idx;
   logic [31:0] rf_rd_data, rf_wdata, pc_wdata, psr_wdata;
   logic        rf_we, pc_we, psr_we;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        busy, done;

   logic [31:0] rf   [16];
   logic [31:0] mem  [64];
   logic [31:0] alog [256];
   int nacc = 0, cyc = 0, last_ack_cyc = 0, done_cyc = 0, wcnt = 0, ws = 0;
   int nrfw = 0, npsrw = 0, sc = 0;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   assign rf_rd_data = rf[rf_rd_idx];

   blkxfer_seq u_blkxfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cmd_mask(cmd_mask), .cmd_base(cmd_base), .cmd_load(cmd_load), .cmd_up(cmd_up),
      .cmd_pre(cmd_pre), .cmd_wb(cmd_wb), .cmd_psr(cmd_psr), .mode_user(mode_user),
      .pc_in(pc_in), .psr_in(psr_in),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wdata(rf_wdata),
      .pc_we(pc_we), .pc_wdata(pc_wdata), .psr_we(psr_we), .psr_wdata(psr_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done)
   );

   // Memory responder, acts away from the rising edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (done) done_cyc = cyc;
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
         if (wcnt >= ws) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[7:2]];
            alog[nacc[7:0]] = mem_addr;
            nacc = nacc + 1;
            last_ack_cyc = cyc;
            wcnt = 0;
         end else begin
            wcnt = wcnt + 1;
         end
      end
   end

   // Register file, program counter and status word owners
   always @(posedge clk) begin
      if (rf_we) begin
         rf[rf_wr_idx] <= rf_wdata;
         nrfw <= nrfw + 1;
      end
      if (pc_we) pc_in <= pc_wdata;
      if (psr_we) begin
         psr_in <= psr_wdata;
         npsrw <= npsrw + 1;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [15:0] m, input logic [3:0] b, input logic ld,
                         input logic up, input logic pre, input logic wb, input logic ps);
      @(negedge clk);
      cmd_mask = m; cmd_base = b; cmd_load = ld; cmd_up = up;
      cmd_pre = pre; cmd_wb = wb; cmd_psr = ps;
      start = 1'b1;
      #1 sc = cyc;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 500) begin
         @(negedge clk);
         t++;
      end
      #1;
      if (t >= 500) check("R10 done timeout", 32'd0, 32'd1);
      @(negedge clk);
   endtask

   task automatic run(input logic [15:0] m, input logic [3:0] b, input logic ld,
                      input logic up, input logic pre, input logic wb, input logic ps);
      int n0 = nacc;
      launch(m, b, ld, up, pre, wb, ps);
      wait_done();
      if (m != 16'h0) check("R10 done one cycle after last ack", done_cyc, last_ack_cyc + 1);
      else begin
         check("R9 done one cycle after accept", done_cyc, sc + 1);
         check("R9 no access for empty mask", nacc, n0);
      end
   endtask

   task automatic t_reset();
      check("R1 busy after reset", {31'd0, busy}, 32'd0);
      check("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
      check("R1 done after reset", {31'd0, done}, 32'd0);
   endtask

   task automatic t_store_up_post();
      int n0 = nacc;
      ws = 1;
      for (int i = 0; i < 15; i++) rf[i] = 32'h1000_0000 + i;
      rf[1] = 32'h40;
      run(16'h00A5, 4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      check("R4 access count", nacc - n0, 4);
      check("R2 first address is base", alog[n0], 32'h40);
      check("R3 post up second address", alog[n0+1], 32'h44);
      check("R4 r0 stored first", mem[16], 32'h1000_0000);
      check("R4 r2 stored second", mem[17], 32'h1000_0002);
      check("R4 r5 stored third", mem[18], 32'h1000_0005);
      check("R4 r7 stored fourth", mem[19], 32'h1000_0007);
      check("R7 base written back", rf[1], 32'h50);
   endtask

   task automatic t_load_down_pre();
      int n0 = nacc;
      ws = 0;
      rf[3] = 32'h80;
      mem[31] = 32'hAAAA_0001;
      mem[30] = 32'hBBBB_0002;
      run(16'h0060, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      check("R3 pre down first address", alog[n0], 32'h7C);
      check("R3 pre down second address", alog[n0+1], 32'h78);
      check("R6 r5 loaded", rf[5], 32'hAAAA_0001);
      check("R6 r6 loaded", rf[6], 32'hBBBB_0002);
      check("R7 base after load and write-back", rf[3], 32'h78);
   endtask

   task automatic t_store_down_post_nowb();
      int n0 = nacc;
      ws = 2;
      rf[4] = 32'hA0;
      rf[0] = 32'hC0C0_0000;
      rf[1] = 32'hC1C1_0001;
      run(16'h0003, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R3 post down first address", alog[n0], 32'hA0);
      check("R3 post down second address", alog[n0+1], 32'h9C);
      check("R4 r1 stored at lower word", mem[39], 32'hC1C1_0001);
      check("R7 no write-back when flag clear", rf[4], 32'hA0);
   endtask

   task automatic t_pc_base_store();
      int n0 = nacc;
      int w0;
      ws = 0;
      pc_in = 32'h30;
      rf[1] = 32'h1111_2222;
      w0 = nrfw;
      run(16'h8002, 4'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      check("R2 pc base gives pc+8", alog[n0], 32'h38);
      check("R5 r15 accessed last", alog[n0+1], 32'h3C);
      check("R4 r1 stored", mem[14], 32'h1111_2222);
      check("R5 r15 stored as pc+12", mem[15], 32'h3C);
      check("R7 no write-back for pc base", nrfw - w0, 0);
   endtask

   task automatic t_pc_load(input logic user, input logic ps, input logic [31:0] exp_psr,
                            input int exp_psrw);
      int p0 = npsrw;
      ws = 1;
      rf[2] = 32'h60;
      mem[24] = 32'hFC00_0001;
      psr_in = 32'h0000_0002;
      pc_in = 32'h200;
      mode_user = user;
      launch(16'h8000, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, ps);
      mode_user = 1'b0;
      wait_done();
      check("R6 pc loaded from memory", pc_in, 32'hFC00_0001);
      check("R8 status word result", psr_in, exp_psr);
      check("R8 status write count", npsrw - p0, exp_psrw);
   endtask

   task automatic t_empty();
      int n0 = nacc;
      rf[1] = 32'h64;
      run(16'h0000, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check("R9 still no access later", nacc, n0);
      check("R9 base unchanged", rf[1], 32'h64);
   endtask

   task automatic t_ignore_start();
      int n0 = nacc;
      ws = 2;
      rf[1] = 32'h40;
      for (int i = 2; i < 6; i++) rf[i] = 32'h5500_0000 + i;
      launch(16'h003C, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      cmd_mask = 16'hFFFF; cmd_base = 4'd0; cmd_load = 1'b1; cmd_up = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (4) @(negedge clk);
      check("R12 access count unaffected", nacc - n0, 4);
      check("R12 busy after completion", {31'd0, busy}, 32'd0);
      check("R12 last address of original command", alog[n0+3], 32'h4C);
      check("R12 data of original command", mem[19], 32'h5500_0005);
   endtask

   task automatic t_unaligned();
      int n0 = nacc;
      ws = 0;
      rf[6] = 32'h43;
      rf[0] = 32'h0A0A_0A0A;
      rf[1] = 32'h0B0B_0B0B;
      run(16'h0003, 4'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R11 first address aligned", alog[n0], 32'h40);
      check("R11 second address aligned", alog[n0+1], 32'h44);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) rf[i] = '0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_store_up_post();
      t_load_down_pre();
      t_store_down_post_nowb();
      t_pc_base_store();
      t_pc_load(1'b1, 1'b1, 32'hF000_0002, 1);
      t_pc_load(1'b0, 1'b1, 32'hFC00_0001, 1);
      t_pc_load(1'b1, 1'b0, 32'h0000_0002, 0);
      t_empty();
      t_ignore_start();
      t_unaligned();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule